// File: doc/BRIEF.md
# Daisy-Chain Bus Priority Request Client

This block is the request and grant logic of a peripheral card on a backplane bus. The bus has four interrupt priority levels and one non-processor level used for DMA. The host side posts a request on any level. An interrupt post carries a 16-bit vector, a status register handle and a status register value. A post on the DMA level only starts the request. All five levels can be pending at the same time, and each keeps its own state and vector.

The block drives one request line per level and watches the five incoming grant lines. If a grant arrives on a level where this card has nothing pending, the block passes it on to the downstream grant output so that other cards on the chain can use it. If a grant arrives on a pending level, the block claims it. It drops the request line, raises the select-acknowledge line and starts a single shared transfer engine. The engine reports the end of the transfer on `xfer_done`. The block then releases the acknowledge line and frees the level. It also raises a completion flag, which stays up until the host acknowledges it.

An interrupt request that has not yet been granted can be cancelled by the host. A new post on a level is accepted only after the completion of the previous request on that level has been signalled.

Top module: `bus_prio_client`

## Requirements
- R1: After synchronous reset, `req_out`, `grant_out`, `busy_mask`, `evt_flags`, `sack_out`, `xfer_start` and `regwr_en` are all zero.
- R2: Level encoding is bit 0 = BR4, bit 1 = BR5, bit 2 = BR6, bit 3 = BR7, bit 4 = NPR. A post on an idle level sets the matching `req_out` bit and `busy_mask` bit one cycle after the post. A post with `post_level` 5, 6 or 7 is ignored.
- R3: An accepted post on an interrupt level (0..3) pulses `regwr_en` for one cycle, carrying the posted handle and value. This happens in the same cycle that the request bit rises. A post on the NPR level produces no register write.
- R4: A grant input on a level with no pending or active request appears on the matching `grant_out` bit one cycle later. A level that requested in two consecutive cycles never forwards its grant.
- R5: A grant on a pending level is claimed if the engine is free. One cycle later the request bit is low, `sack_out` is high, and `xfer_start` pulses for one cycle with the level index and the stored vector (zero for NPR). The claimed grant is not forwarded.
- R6: When several pending levels are granted together, NPR is claimed first, then BR7, BR6, BR5, BR4. While the engine is busy, no other grant is claimed and those grants are not forwarded. At most one level is owned at a time.
- R7: `sack_out` stays high until `xfer_done`. One cycle after `xfer_done`, `sack_out` is low, the level is idle and its `evt_flags` bit is set. `xfer_done` with no transfer running has no effect.
- R8: A post on a level that is pending or owned is ignored. It produces no register write, and the stored vector is unchanged.
- R9: A cancel on a pending interrupt level (`cancel_level` 0..3) drops that request one cycle later and sets no completion flag. A cancel on an idle level has no effect.
- R10: Each `evt_flags` bit stays set until its `evt_ack` bit is pulsed. `intr_evt_valid` is high when any of bits 0..3 is set. `intr_evt_level` gives the highest such index (0 = BR4 .. 3 = BR7).
- R11: All five levels can be pending together, and each interrupt level returns its own vector when claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_valid | input | 1 | Post a request this cycle |
| post_level | input | 3 | Level index of the post (0..4) |
| post_vector | input | VEC_W | Interrupt vector for levels 0..3 |
| post_handle | input | HANDLE_W | Status register handle |
| post_regval | input | REGVAL_W | Status register value |
| cancel_valid | input | 1 | Cancel a pending interrupt request |
| cancel_level | input | 2 | Interrupt level to cancel |
| grant_in | input | 5 | Grant lines from upstream |
| grant_out | output | 5 | Grant lines passed downstream |
| req_out | output | 5 | Request lines to the bus |
| sack_out | output | 1 | Select acknowledge |
| busy_mask | output | 5 | Levels that cannot accept a post |
| regwr_en | output | 1 | Status register write strobe |
| regwr_handle | output | HANDLE_W | Handle of the register write |
| regwr_value | output | REGVAL_W | Value of the register write |
| xfer_start | output | 1 | Start pulse to the transfer engine |
| xfer_level | output | 3 | Level of the started transfer |
| xfer_vector | output | VEC_W | Vector of the started transfer |
| xfer_done | input | 1 | Transfer engine completion |
| evt_flags | output | 5 | Completion flags per level |
| evt_ack | input | 5 | Host acknowledge, clears flags |
| intr_evt_valid | output | 1 | Some interrupt completion is flagged |
| intr_evt_level | output | 2 | Highest flagged interrupt level |

## Verification
Suppose one level slot got into a wrong state. A pending slot lost on the way would show up as a missing or out-of-order `xfer_start` the next time that grant arrives. A slot stuck idle would leak its grant to `grant_out` one cycle after the grant. A broken engine owner would show as `sack_out` staying up, or dropping, in the cycle after `xfer_done`. The bench queues the expected level and vector of every claim, in priority order, and compares each `xfer_start` as it occurs. So a wrong claim order or a stale vector shows up within a cycle of the claim.

// File: rtl/prio_pkg.sv
package prio_pkg;

    localparam int N_INTR   = 4;
    localparam int N_LEVELS = N_INTR + 1;
    localparam int NPR_IDX  = N_INTR;
    localparam int LVL_W    = $clog2(N_LEVELS);
    localparam int INTR_W   = $clog2(N_INTR);

    localparam logic [N_LEVELS-1:0] INTR_MASK = N_LEVELS'((1 << N_INTR) - 1);
    localparam logic [N_LEVELS-1:0] ALL_MASK  = N_LEVELS'((1 << N_LEVELS) - 1);

    typedef logic [N_LEVELS-1:0] lvl_mask_t;

    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_PEND = 2'd1,
        SLOT_OWN  = 2'd2
    } slot_state_e;

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] idx;
    } pick_t;

    // highest set bit wins: NPR above BR7 above ... BR4
    function automatic pick_t pick_highest(lvl_mask_t m);
        pick_t r;
        r = '0;
        for (int i = 0; i < N_LEVELS; i++) begin
            if (m[i]) begin
                r.valid = 1'b1;
                r.idx   = LVL_W'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/prio_level_slot.sv
module prio_level_slot
    import prio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        post_hit,
    input  logic        cancel_hit,
    input  logic        claim_hit,
    input  logic        done_hit,
    output slot_state_e state
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SLOT_IDLE;
        end else begin
            case (state)
                SLOT_IDLE: if (post_hit) state <= SLOT_PEND;
                SLOT_PEND: begin
                    if (claim_hit)       state <= SLOT_OWN;
                    else if (cancel_hit) state <= SLOT_IDLE;
                end
                SLOT_OWN:  if (done_hit) state <= SLOT_IDLE;
                default:   state <= SLOT_IDLE;
            endcase
        end
    end

    AST_CANCEL_DROPS: assert property (@(posedge clk) disable iff (rst)
        (state == SLOT_PEND && cancel_hit && !claim_hit) |=> (state == SLOT_IDLE)); // R9

    AST_OWN_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
        (state == SLOT_OWN && !done_hit) |=> (state == SLOT_OWN)); // R7

endmodule

// File: rtl/prio_claim_sel.sv
module prio_claim_sel
    import prio_pkg::*;
(
    input  lvl_mask_t grant_in,
    input  lvl_mask_t pend_mask,
    input  logic      engine_free,
    output pick_t     claim,
    output lvl_mask_t claim_vec
);

    lvl_mask_t cand;

    assign cand  = grant_in & pend_mask;
    assign claim = engine_free ? pick_highest(cand) : '0;

    for (genvar g = 0; g < N_LEVELS; g++) begin : g_vec
        assign claim_vec[g] = claim.valid && (claim.idx == LVL_W'(g));
    end

endmodule

// File: rtl/prio_event_flags.sv
module prio_event_flags
    import prio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_valid,
    input  logic [LVL_W-1:0]  set_idx,
    input  lvl_mask_t         ack,
    output lvl_mask_t         flags,
    output logic              intr_valid,
    output logic [INTR_W-1:0] intr_idx
);

    lvl_mask_t set_vec;

    for (genvar g = 0; g < N_LEVELS; g++) begin : g_set
        assign set_vec[g] = set_valid && (set_idx == LVL_W'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~ack) | set_vec;
    end

    always_comb begin
        intr_valid = 1'b0;
        intr_idx   = '0;
        for (int i = 0; i < N_INTR; i++) begin
            if (flags[i]) begin
                intr_valid = 1'b1;
                intr_idx   = INTR_W'(i);
            end
        end
    end

    for (genvar g = 0; g < N_LEVELS; g++) begin : g_chk
        AST_FLAG_HELD: assert property (@(posedge clk) disable iff (rst)
            (flags[g] && !ack[g]) |=> flags[g]); // R10
    end

endmodule

// File: rtl/bus_prio_client.sv
module bus_prio_client
    import prio_pkg::*;
#(
    parameter int VEC_W    = 16,
    parameter int HANDLE_W = 8,
    parameter int REGVAL_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                post_valid,
    input  logic [2:0]          post_level,
    input  logic [VEC_W-1:0]    post_vector,
    input  logic [HANDLE_W-1:0] post_handle,
    input  logic [REGVAL_W-1:0] post_regval,
    input  logic                cancel_valid,
    input  logic [1:0]          cancel_level,
    input  logic [4:0]          grant_in,
    output logic [4:0]          grant_out,
    output logic [4:0]          req_out,
    output logic                sack_out,
    output logic [4:0]          busy_mask,
    output logic                regwr_en,
    output logic [HANDLE_W-1:0] regwr_handle,
    output logic [REGVAL_W-1:0] regwr_value,
    output logic                xfer_start,
    output logic [2:0]          xfer_level,
    output logic [VEC_W-1:0]    xfer_vector,
    input  logic                xfer_done,
    output logic [4:0]          evt_flags,
    input  logic [4:0]          evt_ack,
    output logic                intr_evt_valid,
    output logic [1:0]          intr_evt_level
);

    slot_state_e      state [N_LEVELS];
    lvl_mask_t        post_hit, cancel_hit, claim_hit, done_hit;
    lvl_mask_t        idle_mask, pend_mask, own_mask;
    pick_t            claim;
    logic             active_q;
    logic [LVL_W-1:0] act_idx_q;
    logic [VEC_W-1:0] vec_q [N_INTR];
    logic             level_ok, intr_post_ok, done_ev;

    assign level_ok     = post_level < LVL_W'(N_LEVELS);
    assign intr_post_ok = post_valid && (post_level < LVL_W'(N_INTR)) && idle_mask[post_level];
    assign done_ev      = xfer_done && active_q;

    for (genvar g = 0; g < N_LEVELS; g++) begin : g_lvl
        assign post_hit[g]  = post_valid && level_ok && (post_level == LVL_W'(g));
        assign done_hit[g]  = done_ev && (act_idx_q == LVL_W'(g));
        if (g < N_INTR) begin : g_can
            assign cancel_hit[g] = cancel_valid && (cancel_level == INTR_W'(g));
        end else begin : g_nocan
            assign cancel_hit[g] = 1'b0;
        end

        prio_level_slot u_slot (
            .clk        (clk),
            .rst        (rst),
            .post_hit   (post_hit[g]),
            .cancel_hit (cancel_hit[g]),
            .claim_hit  (claim_hit[g]),
            .done_hit   (done_hit[g]),
            .state      (state[g])
        );

        assign idle_mask[g] = (state[g] == SLOT_IDLE);
        assign pend_mask[g] = (state[g] == SLOT_PEND);
        assign own_mask[g]  = (state[g] == SLOT_OWN);
    end

    prio_claim_sel u_claim (
        .grant_in    (grant_in),
        .pend_mask   (pend_mask),
        .engine_free (!active_q),
        .claim       (claim),
        .claim_vec   (claim_hit)
    );

    prio_event_flags u_evt (
        .clk        (clk),
        .rst        (rst),
        .set_valid  (done_ev),
        .set_idx    (act_idx_q),
        .ack        (evt_ack),
        .flags      (evt_flags),
        .intr_valid (intr_evt_valid),
        .intr_idx   (intr_evt_level)
    );

    assign req_out   = pend_mask;
    assign busy_mask = ~idle_mask & ALL_MASK;
    assign sack_out  = active_q;

    // vector storage per interrupt level, written only on an accepted post
    for (genvar g = 0; g < N_INTR; g++) begin : g_vec
        always_ff @(posedge clk) begin
            if (rst)                            vec_q[g] <= '0;
            else if (post_hit[g] && idle_mask[g]) vec_q[g] <= post_vector;
        end
    end

    // transfer engine ownership and start pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            active_q    <= 1'b0;
            act_idx_q   <= '0;
            xfer_start  <= 1'b0;
            xfer_level  <= '0;
            xfer_vector <= '0;
        end else begin
            xfer_start <= claim.valid;
            if (claim.valid) begin
                active_q    <= 1'b1;
                act_idx_q   <= claim.idx;
                xfer_level  <= claim.idx;
                xfer_vector <= (claim.idx < LVL_W'(N_INTR)) ? vec_q[claim.idx[INTR_W-1:0]] : '0;
            end else if (done_ev) begin
                active_q <= 1'b0;
            end
        end
    end

    // downstream grants and status register write, registered
    always_ff @(posedge clk) begin
        if (rst) begin
            grant_out    <= '0;
            regwr_en     <= 1'b0;
            regwr_handle <= '0;
            regwr_value  <= '0;
        end else begin
            grant_out <= grant_in & idle_mask;
            regwr_en  <= intr_post_ok;
            if (intr_post_ok) begin
                regwr_handle <= post_handle;
                regwr_value  <= post_regval;
            end
        end
    end

    AST_START_WITH_SACK: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> sack_out); // R5

    AST_NO_FWD_HELD_REQ: assert property (@(posedge clk) disable iff (rst)
        (($past(req_out) & req_out & grant_out) == '0)); // R4

    AST_SACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (sack_out && xfer_done) |=> !sack_out); // R7

    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (rst)
        ($countones(own_mask) <= 1)); // R6

    for (genvar g = 0; g < N_INTR; g++) begin : g_rw_chk
        AST_REGWR_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
            $rose(req_out[g]) |-> regwr_en); // R3
    end

endmodule

// File: tb/test_bus_prio_client.sv
`timescale 1ns/1ps
module test_bus_prio_client;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        post_valid = 1'b0;
    logic [2:0]  post_level = '0;
    logic [15:0] post_vector = '0;
    logic [7:0]  post_handle = '0;
    logic [15:0] post_regval = '0;
    logic        cancel_valid = 1'b0;
    logic [1:0]  cancel_level = '0;
    logic [4:0]  grant_in = '0;
    logic [4:0]  grant_out, req_out, busy_mask, evt_flags;
    logic        sack_out, regwr_en, xfer_start, intr_evt_valid;
    logic [7:0]  regwr_handle;
    logic [15:0] regwr_value, xfer_vector;
    logic [2:0]  xfer_level;
    logic        xfer_done = 1'b0;
    logic [4:0]  evt_ack = '0;
    logic [1:0]  intr_evt_level;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct { logic [2:0] lvl; logic [15:0] vec; } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    bus_prio_client i_bus_prio_client (
        .clk(clk), .rst(rst), .post_valid(post_valid), .post_level(post_level),
        .post_vector(post_vector), .post_handle(post_handle), .post_regval(post_regval),
        .cancel_valid(cancel_valid), .cancel_level(cancel_level), .grant_in(grant_in),
        .grant_out(grant_out), .req_out(req_out), .sack_out(sack_out), .busy_mask(busy_mask),
        .regwr_en(regwr_en), .regwr_handle(regwr_handle), .regwr_value(regwr_value),
        .xfer_start(xfer_start), .xfer_level(xfer_level), .xfer_vector(xfer_vector),
        .xfer_done(xfer_done), .evt_flags(evt_flags), .evt_ack(evt_ack),
        .intr_evt_valid(intr_evt_valid), .intr_evt_level(intr_evt_level)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic push_exp(logic [2:0] l, logic [15:0] v);
        exp_t e;
        e.lvl = l;
        e.vec = v;
        sb_q.push_back(e);
    endtask

    task automatic post(logic [2:0] l, logic [15:0] v, logic [7:0] h, logic [15:0] rv);
        post_valid = 1'b1; post_level = l; post_vector = v; post_handle = h; post_regval = rv;
        tick();
        post_valid = 1'b0;
    endtask

    task automatic cancel(logic [1:0] l);
        cancel_valid = 1'b1; cancel_level = l;
        tick();
        cancel_valid = 1'b0;
    endtask

    task automatic serve();
        for (int k = 0; k < 10 && !sack_out; k++) tick();
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;
        chk("R7 sack released after done", 32'(sack_out), 32'd0);
    endtask

    // scoreboard monitor: every start pulse must match the next expected claim
    always @(negedge clk) begin
        if (!rst && xfer_start) begin
            n_chk++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL R5 unexpected start: actual lvl %0d vec %h expected none",
                         xfer_level, xfer_vector);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (xfer_level !== e.lvl || xfer_vector !== e.vec) begin
                    n_fail++;
                    $display("FAIL R6/R11 claim: actual lvl %0d vec %h expected lvl %0d vec %h",
                             xfer_level, xfer_vector, e.lvl, e.vec);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1
        chk("R1 req", 32'(req_out), 0);
        chk("R1 grant_out", 32'(grant_out), 0);
        chk("R1 busy", 32'(busy_mask), 0);
        chk("R1 flags", 32'(evt_flags), 0);
        chk("R1 sack", 32'(sack_out), 0);
        chk("R1 start/regwr", 32'({xfer_start, regwr_en}), 0);

        // R2 / R3: post BR5
        post(3'd1, 16'h1234, 8'h21, 16'hBEEF);
        chk("R2 req BR5", 32'(req_out), 32'h02);
        chk("R2 busy BR5", 32'(busy_mask), 32'h02);
        chk("R3 regwr same cycle", 32'(regwr_en), 1);
        chk("R3 handle", 32'(regwr_handle), 32'h21);
        chk("R3 value", 32'(regwr_value), 32'hBEEF);
        tick();
        chk("R3 regwr one pulse", 32'(regwr_en), 0);

        // R2: invalid level ignored
        post(3'd6, 16'hAAAA, 8'h66, 16'h6666);
        chk("R2 invalid level req", 32'(req_out), 32'h02);
        chk("R2 invalid level busy", 32'(busy_mask), 32'h02);
        chk("R2 invalid level regwr", 32'(regwr_en), 0);

        // R3: NPR post has no register write
        post(3'd4, 16'hFFFF, 8'h44, 16'h4444);
        chk("R2 req NPR", 32'(req_out), 32'h12);
        chk("R3 no regwr for NPR", 32'(regwr_en), 0);

        // R4: grant on idle level forwarded
        grant_in = 5'b00001;
        tick();
        chk("R4 forward BR4", 32'(grant_out), 32'h01);
        grant_in = '0;
        tick();
        chk("R4 forward ends", 32'(grant_out), 0);

        // R8: post on pending level ignored
        post(3'd1, 16'h9999, 8'h99, 16'h9999);
        chk("R8 no regwr on busy level", 32'(regwr_en), 0);
        chk("R8 req unchanged", 32'(req_out), 32'h12);

        // R5 / R6: BR5 and NPR granted together, NPR first
        push_exp(3'd4, 16'h0000);
        grant_in = 5'b10010;
        tick();
        chk("R5 sack", 32'(sack_out), 1);
        chk("R5 NPR req dropped", 32'(req_out), 32'h02);
        chk("R5 claimed grant not forwarded", 32'(grant_out), 0);
        tick();
        chk("R6 BR5 waits while busy", 32'(req_out), 32'h02);
        chk("R6 no forward while busy", 32'(grant_out), 0);
        push_exp(3'd1, 16'h1234);
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;
        chk("R7 sack low after done", 32'(sack_out), 0);
        chk("R7 NPR flag", 32'(evt_flags), 32'h10);
        tick();
        chk("R6 BR5 claimed next", 32'(sack_out), 1);
        chk("R6 BR5 req dropped", 32'(req_out), 0);
        grant_in = '0;
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;
        chk("R10 flags", 32'(evt_flags), 32'h12);
        chk("R10 intr valid", 32'(intr_evt_valid), 1);
        chk("R10 intr level", 32'(intr_evt_level), 1);

        // R11: all five pending together
        post(3'd3, 16'h00C8, 8'h73, 16'h0007);
        chk("R3 BR7 handle", 32'(regwr_handle), 32'h73);
        post(3'd0, 16'h0040, 8'h40, 16'h0004);
        post(3'd2, 16'h0070, 8'h60, 16'h0006);
        post(3'd1, 16'h0055, 8'h50, 16'h0005);
        post(3'd4, 16'h0000, 8'h00, 16'h0000);
        chk("R11 all five pending", 32'(req_out), 32'h1F);

        // R9: cancel BR6
        cancel(2'd2);
        chk("R9 cancel drops BR6", 32'(req_out), 32'h1B);
        chk("R9 no flag from cancel", 32'(evt_flags), 32'h12);

        // R10: ack NPR only, BR5 held
        evt_ack = 5'h10;
        tick();
        evt_ack = '0;
        chk("R10 ack clears one", 32'(evt_flags), 32'h02);
        repeat (3) tick();
        chk("R10 flag held", 32'(evt_flags), 32'h02);

        // R6 / R11: grant all, priority order with per-level vectors
        push_exp(3'd4, 16'h0000);
        push_exp(3'd3, 16'h00C8);
        push_exp(3'd1, 16'h0055);
        push_exp(3'd0, 16'h0040);
        grant_in = 5'h1F;
        tick();
        chk("R4 cancelled BR6 grant forwarded", 32'(grant_out[2]), 1);
        for (int n = 0; n < 4; n++) serve();
        grant_in = '0;
        tick();
        chk("R11 no requests left", 32'(req_out), 0);
        chk("R10 flags after all", 32'(evt_flags), 32'h1B);
        chk("R10 highest intr level", 32'(intr_evt_level), 3);
        evt_ack = 5'h08;
        tick();
        evt_ack = '0;
        chk("R10 next highest", 32'(intr_evt_level), 1);
        evt_ack = 5'h1F;
        tick();
        evt_ack = '0;
        chk("R10 all cleared", 32'(evt_flags), 0);
        chk("R10 intr valid low", 32'(intr_evt_valid), 0);

        // R7 / R9: stray done and cancel on idle
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;
        chk("R7 stray done no flag", 32'(evt_flags), 0);
        chk("R7 stray done no sack", 32'(sack_out), 0);
        cancel(2'd0);
        chk("R9 cancel idle no effect", 32'(busy_mask), 0);

        tick();
        chk("R5 scoreboard drained", 32'(sb_q.size()), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule